// File: doc/BRIEF.md
# DMA External Request Grant Arbiter

This block picks which of several DMA channels runs the next burst, and handles the request/grant handshake for one external request pin. Each channel has three configuration bits: an enable bit, a repeat-enable bit and a source select. The source select ties the channel either to its own internal peripheral request line or to the shared external request pin. A channel can compete only when both its enable and its repeat-enable bits are set. All requests pass through a synchronizer. After that, the lowest-numbered pending channel wins, with one exception described below.

A burst is modelled as a programmable number of busy cycles. While a burst runs for a channel that uses the external pin, an active-low grant output is driven low. The external pin is not looked at again until that burst is over. After every burst there is a short settling window that lets a withdrawn request reach the arbiter through the synchronizer. When an external burst ends while another eligible request is pending, the external request drops to lowest priority for the next decision.

Top module: `dma_ext_arbiter`

## Requirements
- R1: While `rstN` is low, `extGrantN` is 1, `burstBusy` is 0 and `burstStart` is 0. The arbiter comes out of reset idle, with no priority penalty in effect.
- R2: Channel i is pending only when `chEnable[i]` and `chRepeat[i]` are both 1. Its request is `extReq` when `chSrcExt[i]` is 1 and `periphReq[i]` when `chSrcExt[i]` is 0. A channel that is not eligible, or a request line that is not selected, never starts a burst.
- R3: A request that is raised while the arbiter is idle and is first sampled at rising edge k produces `burstStart` high in the cycle after edge k+2. `burstBusy` is still 0 in the cycle before that.
- R4: Apart from the penalty of R9, the pending channel with the lowest index wins. `burstChan` gives the winner's index and holds it for the whole burst.
- R5: A burst keeps `burstBusy` high for `burstLen` cycles, and for one cycle when `burstLen` is 0. `burstStart` is high in the first of these cycles and `burstDone` in the last. `burstBusy` is 0 in the cycle after `burstDone`.
- R6: `extGrantN` is 0 in exactly the busy cycles of bursts whose channel had `chSrcExt` set to 1 when the burst started. It is 1 at all other times.
- R7: Once granted, `extGrantN` stays low for the full burst even if `extReq` is withdrawn at once. The shortest grant is one cycle.
- R8: Requests are not sampled for arbitration during a burst or during the two cycles after it. A request still pending then starts its burst exactly four cycles after the `burstDone` cycle. An external request withdrawn in the cycle after the grant is first seen therefore produces exactly one burst.
- R9: If an external-sourced burst completes while an eligible internal-sourced channel is pending, the next decision ranks external-sourced channels below all others. The penalty is cleared when the next burst starts.
- R10: An external request held continuously with no competitor gets back-to-back bursts, each separated by the R8 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chEnable | input | NUM_CH | Per-channel enable bit |
| chRepeat | input | NUM_CH | Per-channel repeat-enable bit |
| chSrcExt | input | NUM_CH | 1 = channel follows the external request pin, 0 = its internal request |
| periphReq | input | NUM_CH | Internal peripheral request per channel (asynchronous) |
| extReq | input | 1 | External device request (asynchronous, active high) |
| burstLen | input | LEN_W | Burst length in cycles (0 is treated as 1) |
| extGrantN | output | 1 | Active-low grant to the external device |
| burstBusy | output | 1 | A burst is in progress |
| burstChan | output | CH_W | Channel of the current burst |
| burstStart | output | 1 | First cycle of a burst |
| burstDone | output | 1 | Last cycle of a burst |

## Verification
The assertions assume that `chEnable`, `chRepeat`, `chSrcExt` and `burstLen` change only while no burst is running. They also assume that the external device keeps `extReq` high until it sees the grant, so every grant follows a request that the arbiter really saw. The stimulus changes configuration only after long idle gaps. It drops each request in the cycle after that channel's `burstStart`, which falls inside the R8 window for every burst length used. The penalty case uses a four-cycle burst, so that the competing request has passed through the synchronizer by the time the external burst completes.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_SETTLE = 2'd2
  } arbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic startBurst;
    logic endBurst;
    logic penaltyOn;
  } arbStrobe_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[CHAIN_W-WIDTH-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             anyPend,
  input  logic             otherPend,
  input  logic             curIsExt,
  output arbStrobe_t       strobe,
  output logic             busy,
  output logic             startPulse,
  output logic             donePulse
);

  localparam int SET_W = $clog2(SYNC_STAGES + 1);
  localparam int CNT_W = (LEN_W > SET_W) ? LEN_W : SET_W;

  arbState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic              penalty;
  logic              startFlag;
  logic              startBurst;
  logic              endBurst;
  logic [CNT_W-1:0]  firstCnt;

  assign startBurst = (state == ST_IDLE) && anyPend;
  assign endBurst   = (state == ST_BURST) && (cnt == '0);
  assign firstCnt   = (burstLen == '0) ? '0 : (CNT_W'(burstLen) - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      penalty   <= 1'b0;
      startFlag <= 1'b0;
    end else begin
      startFlag <= startBurst;
      unique case (state)
        ST_IDLE: begin
          if (startBurst) begin
            state   <= ST_BURST;
            cnt     <= firstCnt;
            penalty <= 1'b0;
          end
        end
        ST_BURST: begin
          if (endBurst) begin
            state   <= ST_SETTLE;
            cnt     <= CNT_W'(SYNC_STAGES - 1);
            penalty <= curIsExt && otherPend;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.startBurst = startBurst;
  assign strobe.endBurst   = endBurst;
  assign strobe.penaltyOn  = penalty;
  assign busy              = (state == ST_BURST);
  assign startPulse        = startFlag;
  assign donePulse         = endBurst;

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chRepeat,
  input  logic [NUM_CH-1:0] chSrcExt,
  input  logic [NUM_CH-1:0] periphSync,
  input  logic              extSync,
  input  arbStrobe_t        strobe,
  output logic              anyPend,
  output logic              otherPend,
  output logic              curIsExt,
  output logic [CH_W-1:0]   curChan,
  output logic              extGrantN
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] favoured;
  logic [NUM_CH-1:0] pickSet;
  logic [CH_W-1:0]   winIdx;
  logic              winIsExt;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_pend
      assign pend[i] = chEnable[i] && chRepeat[i] &&
                       (chSrcExt[i] ? extSync : periphSync[i]);
    end
  endgenerate

  assign favoured  = strobe.penaltyOn ? (pend & ~chSrcExt) : pend;
  assign pickSet   = (|favoured) ? favoured : pend;
  assign anyPend   = |pend;
  assign otherPend = |(pend & ~chSrcExt);

  always_comb begin
    winIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pickSet[i]) winIdx = CH_W'(i);
    end
  end

  assign winIsExt = chSrcExt[winIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan   <= '0;
      curIsExt  <= 1'b0;
      extGrantN <= 1'b1;
    end else if (strobe.startBurst) begin
      curChan   <= winIdx;
      curIsExt  <= winIsExt;
      extGrantN <= !winIsExt;
    end else if (strobe.endBurst) begin
      extGrantN <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_ext_arbiter.sv
module dma_ext_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [NUM_CH-1:0] chRepeat,
  input  logic [NUM_CH-1:0] chSrcExt,
  input  logic [NUM_CH-1:0] periphReq,
  input  logic              extReq,
  input  logic [LEN_W-1:0]  burstLen,
  output logic              extGrantN,
  output logic              burstBusy,
  output logic [CH_W-1:0]   burstChan,
  output logic              burstStart,
  output logic              burstDone
);

  logic [NUM_CH:0]   reqSync;
  arbStrobe_t        strobe;
  logic              anyPend;
  logic              otherPend;
  logic              curIsExt;

  dma_req_sync #(
    .WIDTH (NUM_CH + 1),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({extReq, periphReq}),
    .syncOut(reqSync)
  );

  dma_arb_ctrl #(
    .LEN_W      (LEN_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .burstLen  (burstLen),
    .anyPend   (anyPend),
    .otherPend (otherPend),
    .curIsExt  (curIsExt),
    .strobe    (strobe),
    .busy      (burstBusy),
    .startPulse(burstStart),
    .donePulse (burstDone)
  );

  dma_arb_datapath #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .chEnable  (chEnable),
    .chRepeat  (chRepeat),
    .chSrcExt  (chSrcExt),
    .periphSync(reqSync[NUM_CH-1:0]),
    .extSync   (reqSync[NUM_CH]),
    .strobe    (strobe),
    .anyPend   (anyPend),
    .otherPend (otherPend),
    .curIsExt  (curIsExt),
    .curChan   (burstChan),
    .extGrantN (extGrantN)
  );

endmodule

// File: rtl/dma_ext_arbiter_checker.sv
module dma_ext_arbiter_checker #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            extGrantN,
  input logic            burstBusy,
  input logic [CH_W-1:0] burstChan,
  input logic            burstStart,
  input logic            burstDone
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (extGrantN && !burstBusy && !burstStart)); // R1

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> (burstBusy && !$past(burstBusy))); // R3

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (burstBusy && !burstStart) |-> $stable(burstChan)); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstBusy); // R5

  AST_GRANT_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    !extGrantN |-> burstBusy); // R6

  AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (burstBusy && !burstDone && !extGrantN) |=> !extGrantN); // R7

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstStart ##1 !burstStart); // R8

endmodule

bind dma_ext_arbiter dma_ext_arbiter_checker #(
  .CH_W(CH_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .extGrantN (extGrantN),
  .burstBusy (burstBusy),
  .burstChan (burstChan),
  .burstStart(burstStart),
  .burstDone (burstDone)
);

// File: tb/dma_ext_arbiter_bench.sv
`timescale 1ns/1ps
module dma_ext_arbiter_bench;

  localparam int NCH = 4;
  localparam int LW  = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b1;
  logic [NCH-1:0] chEnable, chRepeat, chSrcExt, periphReq;
  logic          extReq;
  logic [LW-1:0] burstLen;
  logic          extGrantN, burstBusy, burstStart, burstDone;
  logic [1:0]    burstChan;

  always #4 clk = ~clk;

  dma_ext_arbiter #(.NUM_CH(NCH), .LEN_W(LW), .SYNC_STAGES(2)) u_dma_ext_arbiter (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .chRepeat(chRepeat),
    .chSrcExt(chSrcExt), .periphReq(periphReq), .extReq(extReq),
    .burstLen(burstLen), .extGrantN(extGrantN), .burstBusy(burstBusy),
    .burstChan(burstChan), .burstStart(burstStart), .burstDone(burstDone)
  );

  typedef struct {
    int    chan;
    bit    isExt;
    int    len;
    string tag;
  } item_t;

  item_t expQ[$];
  int    startLog[$];
  int    checks = 0;
  int    errors = 0;
  int    cycle = 0;
  int    lastGrantLow = 0;
  bit    finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectBurst(int ch, bit ext, int len, string tag);
    item_t it;
    it.chan = ch; it.isExt = ext; it.len = len; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic waitStarts(int target, string req);
    int guard = 0;
    while (startLog.size() < target && guard < 400) begin
      tick();
      guard++;
    end
    chk(req, "burst start reached", startLog.size() >= target, 1);
  endtask

  // monitor / scoreboard
  item_t cur;
  bit    active = 0;
  int    runLen = 0;
  int    grantLow = 0;

  always @(negedge clk) begin
    if (rstN) begin
      cycle++;
      if (burstStart) begin
        startLog.push_back(cycle);
        if (expQ.size() == 0) begin
          chk("R2", "unexpected burst channel", burstChan, -1);
          active = 0;
        end else begin
          cur = expQ.pop_front();
          active = 1;
          runLen = 0;
          grantLow = 0;
          chk(cur.tag, "burst channel", burstChan, cur.chan);
        end
      end
      if (burstBusy && active) begin
        runLen++;
        if (!extGrantN) grantLow++;
        chk("R6", "grant level in burst", extGrantN, cur.isExt ? 0 : 1);
        if (burstDone) begin
          chk("R5", "burst length", runLen, cur.len);
          lastGrantLow = grantLow;
        end
      end
      if (!burstBusy) begin
        active = 0;
        chk("R6", "grant idle level", extGrantN, 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    chEnable = 4'hF; chRepeat = 4'hF; chSrcExt = 4'b0100;
    periphReq = '0; extReq = 1'b0; burstLen = 4'd3;
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "grant in reset", extGrantN, 1);
    chk("R1", "busy in reset", burstBusy, 0);
    chk("R1", "start in reset", burstStart, 0);
    rstN = 1'b1;
    idle(3);

    // R3: latency from first sampling edge to burst start
    expectBurst(1, 0, 3, "R3");
    periphReq[1] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R3", "busy before start cycle", burstBusy, 0);
    @(negedge clk);
    chk("R3", "start three edges later", burstStart, 1);
    tick();
    periphReq[1] = 1'b0;
    idle(20);

    // R4: fixed priority, lowest index first
    base = startLog.size();
    expectBurst(1, 0, 3, "R4");
    expectBurst(3, 0, 3, "R4");
    periphReq[1] = 1'b1; periphReq[3] = 1'b1;
    waitStarts(base + 1, "R4");
    periphReq[1] = 1'b0;
    waitStarts(base + 2, "R4");
    periphReq[3] = 1'b0;
    idle(20);

    // R2: repeat bit cleared on ch0, unselected internal line on ext channel 2
    base = startLog.size();
    chRepeat[0] = 1'b0;
    expectBurst(3, 0, 3, "R2");
    periphReq[0] = 1'b1; periphReq[2] = 1'b1; periphReq[3] = 1'b1;
    waitStarts(base + 1, "R2");
    periphReq[3] = 1'b0;
    idle(30);
    chk("R2", "ineligible requests start nothing", startLog.size() - base, 1);
    periphReq = '0;
    idle(6);
    chRepeat[0] = 1'b1;
    idle(6);

    // R5: zero length counts as one cycle
    burstLen = 4'd0;
    base = startLog.size();
    expectBurst(1, 0, 1, "R5");
    periphReq[1] = 1'b1;
    waitStarts(base + 1, "R5");
    periphReq[1] = 1'b0;
    idle(20);

    // R7 / R8: external request withdrawn right after grant
    burstLen = 4'd3;
    base = startLog.size();
    expectBurst(2, 1, 3, "R6");
    extReq = 1'b1;
    waitStarts(base + 1, "R7");
    extReq = 1'b0;
    idle(30);
    chk("R7", "grant low cycles", lastGrantLow, 3);
    chk("R8", "single burst after withdrawal", startLog.size() - base, 1);

    burstLen = 4'd1;
    base = startLog.size();
    expectBurst(2, 1, 1, "R7");
    extReq = 1'b1;
    waitStarts(base + 1, "R7");
    extReq = 1'b0;
    idle(30);
    chk("R7", "minimum grant cycles", lastGrantLow, 1);
    chk("R8", "single short burst after withdrawal", startLog.size() - base, 1);

    // R10 / R8: held external request repeats with settle window
    burstLen = 4'd2;
    base = startLog.size();
    expectBurst(2, 1, 2, "R10");
    expectBurst(2, 1, 2, "R10");
    expectBurst(2, 1, 2, "R10");
    extReq = 1'b1;
    waitStarts(base + 3, "R10");
    extReq = 1'b0;
    idle(30);
    chk("R10", "held request burst count", startLog.size() - base, 3);
    if (startLog.size() >= base + 2)
      chk("R8", "start to start spacing", startLog[base+1] - startLog[base], 5);

    // R9: penalty after external burst, then fixed priority again
    burstLen = 4'd4;
    base = startLog.size();
    expectBurst(2, 1, 4, "R9");
    expectBurst(3, 0, 4, "R9");
    expectBurst(2, 1, 4, "R9");
    expectBurst(3, 0, 4, "R9");
    extReq = 1'b1;
    waitStarts(base + 1, "R9");
    periphReq[3] = 1'b1;
    waitStarts(base + 3, "R9");
    extReq = 1'b0;
    waitStarts(base + 4, "R9");
    periphReq[3] = 1'b0;
    idle(30);
    chk("R9", "penalty sequence length", startLog.size() - base, 4);

    chk("R4", "all expected bursts seen", expQ.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule